// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital regulator for one winding of a stepper motor bridge. The winding is driven until a synchronous current-sense comparator reports that the peak current has been reached. The bridge then leaves drive for an off-time of a fixed length, timed by a one-shot counter, and goes back to drive on its own. The cycle repeats for as long as the outputs are enabled. Off-time and blanking are counted in system clock cycles.

Each switch into drive starts a blanking window. During that window the comparator is ignored, so recovery and switching transients cannot end the drive early. The decay applied during the off-time is chosen from a three-way off-time source code, a full-step flag and a flag that gives the direction of the current step. It is either slow decay for the whole off-time, or mixed decay: fast decay first, then slow decay. With the two fixed source codes, a built-in cycle count sets the off-time. With the programmable source code, a loaded count sets it. The decay choice, the off-time and the fast-decay split are all captured at the moment of the trip.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset before any enabled clock edge, `phase` is 2'b00 (all off). Phase codes are: 00 off, 01 drive, 10 slow decay, 11 fast decay.
- R2: After every entry into drive, `trip` is ignored for the first BLANK_CYC cycles of drive. `phase` stays 01 during that window whatever `trip` does.
- R3: When `trip` is high in a drive cycle after the blanking window, `phase` leaves drive on the next cycle. After exactly the off-time in cycles, it returns to 01, and a fresh blanking window starts.
- R4: For `src_sel` 0 or 1, the off-time is TOFF_FIXED cycles. For `src_sel` 2 or 3 (bit 1 set), it is `toff_load`, and a load of 0 counts as 1. The value is captured at the trip edge, so later changes have no effect until the next trip.
- R5: In a mixed-decay off-time, `phase` is 11 for the first F cycles and 10 for the rest. F is toff/3 (integer division) when `fast_load` is 0, and otherwise `fast_load` limited to toff.
- R6: With `src_sel` 0, decay is slow for the whole off-time when `full_step` is 1 or `cur_rising` is 1. Otherwise it is mixed.
- R7: With `src_sel` 1, decay is mixed for both rising and falling steps, except that `full_step` 1 forces slow decay.
- R8: With `src_sel` bit 1 set, decay is always mixed, full step included.
- R9: `out_en` low forces `phase` to 00 in the same cycle and cancels any pending off-time or blanking. When it returns high, drive resumes after one clock edge, with a full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 1 | Bridge outputs enable, 1 = enabled |
| trip | input | 1 | Synchronous peak-current comparator output |
| src_sel | input | 2 | Off-time source: 0 auto, 1 both-directions mixed, 2/3 programmable |
| full_step | input | 1 | Step mode is full step |
| cur_rising | input | 1 | Current step is increasing |
| toff_load | input | CW | Programmable off-time in cycles |
| fast_load | input | CW | Fast-decay length in cycles, 0 = one third of off-time |
| phase | output | 2 | Bridge command: 00 off, 01 drive, 10 slow, 11 fast |

## Verification
The assertions assume that `trip` is already synchronous to `clk`. The fast-decay assertions also assume that the off-time they see is at least three cycles whenever `fast_load` is 0, so that a default split is never empty. The stimulus drives every input on the falling edge only. It loads the fixed off-time with a value of three or more, and it gives programmable off-times below three only in cycles where the relevant assertion's antecedent excludes them. Random trips, enable drops and mode changes are mixed with directed runs that time each decay shape and the clamped, zero and default split cases.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'b00,
    PH_DRIVE = 2'b01,
    PH_SLOW  = 2'b10,
    PH_FAST  = 2'b11
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DRIVE = 2'b01,
    ST_OFF   = 2'b10
  } chop_st_t;

  localparam logic [1:0] SRC_AUTO = 2'd0;
  localparam logic [1:0] SRC_BOTH = 2'd1;
endpackage

// File: rtl/chop_decay_sel.sv
module chop_decay_sel #(
  parameter int CW         = 16,
  parameter int TOFF_FIXED = 6000
) (
  input  logic [1:0]    src_sel,
  input  logic          full_step,
  input  logic          cur_rising,
  input  logic [CW-1:0] toff_load,
  input  logic [CW-1:0] fast_load,
  output logic          mixed,
  output logic [CW-1:0] toff_len,
  output logic [CW-1:0] fast_len
);
  import chop_pkg::*;

  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] FIXED = CW'(TOFF_FIXED);

  // Off-time length: built-in for the fixed sources, loaded otherwise.
  function automatic logic [CW-1:0] pick_toff(input logic [1:0] s, input logic [CW-1:0] ld);
    if (s[1]) return (ld == '0) ? ONE : ld;
    return FIXED;
  endfunction

  // Fast-decay length: one third by default, else the load capped at the off-time.
  function automatic logic [CW-1:0] pick_fast(input logic [CW-1:0] t, input logic [CW-1:0] ld);
    if (ld == '0) return t / CW'(3);
    if (ld > t)   return t;
    return ld;
  endfunction

  // Decay mode choice from source, step size and current direction.
  function automatic logic pick_mixed(input logic [1:0] s, input logic fs, input logic rise);
    if (s[1])            return 1'b1;
    if (fs)              return 1'b0;
    if (s == SRC_BOTH)   return 1'b1;
    return !rise;
  endfunction

  always_comb begin
    toff_len = pick_toff(src_sel, toff_load);
    fast_len = pick_fast(toff_len, fast_load);
    mixed    = pick_mixed(src_sel, full_step, cur_rising);
  end
endmodule

// File: rtl/chop_blanker.sv
module chop_blanker #(
  parameter int BLANK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic busy
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (start)      cnt <= BW'(BLANK_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int CW         = 16,
  parameter int TOFF_FIXED = 6000,
  parameter int BLANK_CYC  = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_en,
  input  logic          trip,
  input  logic [1:0]    src_sel,
  input  logic          full_step,
  input  logic          cur_rising,
  input  logic [CW-1:0] toff_load,
  input  logic [CW-1:0] fast_load,
  output logic [1:0]    phase
);
  import chop_pkg::*;

  chop_st_t      st;
  logic [CW-1:0] ocnt;
  logic [CW-1:0] lat_toff;
  logic [CW-1:0] lat_fast;
  logic          lat_mixed;

  logic          sel_mixed;
  logic [CW-1:0] sel_toff;
  logic [CW-1:0] sel_fast;

  // Named internal events.
  logic blank_busy;
  logic trip_take;
  logic off_done;
  logic drive_entry;

  chop_decay_sel #(.CW(CW), .TOFF_FIXED(TOFF_FIXED)) u_sel (
    .src_sel   (src_sel),
    .full_step (full_step),
    .cur_rising(cur_rising),
    .toff_load (toff_load),
    .fast_load (fast_load),
    .mixed     (sel_mixed),
    .toff_len  (sel_toff),
    .fast_len  (sel_fast)
  );

  chop_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(!out_en),
    .start(drive_entry),
    .busy (blank_busy)
  );

  assign trip_take   = out_en && (st == ST_DRIVE) && !blank_busy && trip;
  assign off_done    = (st == ST_OFF) && (ocnt == lat_toff - 1'b1);
  assign drive_entry = out_en && ((st == ST_IDLE) || off_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ocnt      <= '0;
      lat_toff  <= '0;
      lat_fast  <= '0;
      lat_mixed <= 1'b0;
    end else if (!out_en) begin
      st   <= ST_IDLE;
      ocnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: st <= ST_DRIVE;
        ST_DRIVE: begin
          if (trip_take) begin
            st        <= ST_OFF;
            ocnt      <= '0;
            lat_toff  <= sel_toff;
            lat_fast  <= sel_fast;
            lat_mixed <= sel_mixed;
          end
        end
        ST_OFF: begin
          if (off_done) st <= ST_DRIVE;
          else          ocnt <= ocnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!out_en) phase = PH_OFF;
    else begin
      unique case (st)
        ST_DRIVE: phase = PH_DRIVE;
        ST_OFF:   phase = (lat_mixed && (ocnt < lat_fast)) ? PH_FAST : PH_SLOW;
        default:  phase = PH_OFF;
      endcase
    end
  end
endmodule

// File: rtl/chop_checker.sv
module chop_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_en,
  input logic [1:0]    src_sel,
  input logic          full_step,
  input logic          cur_rising,
  input logic [CW-1:0] toff_load,
  input logic [CW-1:0] fast_load,
  input logic [1:0]    phase,
  input logic          blank_busy,
  input logic          trip_take
);
  // R9: a disabled cycle leaves the bridge all-off on the next cycle too.
  p_off_after_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (phase == 2'b00));

  // R2: no decay phase can follow a blanked drive cycle.
  p_blank_holds_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && blank_busy) |=> !phase[1]);

  // R3: an accepted trip leaves drive on the next cycle unless disabled.
  p_trip_leaves_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_take |=> (phase[1] || !out_en));

  // R5: slow decay is never followed by fast decay.
  p_fast_precedes_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b10) |=> (phase != 2'b11));

  // R6: auto source with rising current or full step gives slow decay.
  p_auto_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_take && src_sel == 2'd0 && (cur_rising || full_step)) |=> (phase != 2'b11));

  // R7: both-directions source in microstep mode starts with fast decay.
  p_both_mixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_take && src_sel == 2'd1 && !full_step) |=> (phase == 2'b11 || !out_en));

  // R8: programmable source mixes even in full step.
  p_prog_mixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_take && src_sel[1] && (fast_load != '0 || toff_load >= CW'(3)) && toff_load != '0)
      |=> (phase == 2'b11 || !out_en));
endmodule

bind offtime_chopper chop_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_en    (out_en),
  .src_sel   (src_sel),
  .full_step (full_step),
  .cur_rising(cur_rising),
  .toff_load (toff_load),
  .fast_load (fast_load),
  .phase     (phase),
  .blank_busy(blank_busy),
  .trip_take (trip_take)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LW = 8;
  localparam int LB = 4;
  localparam int LT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          out_en = 1'b0;
  logic          trip = 1'b0;
  logic [1:0]    src_sel = 2'd0;
  logic          full_step = 1'b0;
  logic          cur_rising = 1'b0;
  logic [LW-1:0] toff_load = '0;
  logic [LW-1:0] fast_load = '0;
  logic [1:0]    phase;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference state kept in terms of the requirements.
  int m_st = 0;       // 0 idle, 1 drive, 2 off
  int m_blank = 0;    // drive cycles still blanked
  int m_pos = 0;      // cycles already spent off
  int m_len = 1;
  int m_fast = 0;
  bit m_mix = 0;

  always #2.5 clk = ~clk;

  offtime_chopper #(.CW(LW), .TOFF_FIXED(LT), .BLANK_CYC(LB)) u_offtime_chopper (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .trip(trip), .src_sel(src_sel),
    .full_step(full_step), .cur_rising(cur_rising), .toff_load(toff_load),
    .fast_load(fast_load), .phase(phase)
  );

  function automatic int ref_off(input int s, input int ld);
    return (s >= 2) ? ((ld < 1) ? 1 : ld) : LT;
  endfunction

  function automatic int ref_split(input int len, input int ld);
    if (ld == 0) return len / 3;
    return (ld < len) ? ld : len;
  endfunction

  function automatic bit ref_mixed(input int s, input bit fs, input bit up);
    case (s)
      0:       return !fs && !up;
      1:       return !fs;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int ref_phase();
    if (!out_en || m_st == 0) return 0;
    if (m_st == 1) return 1;
    return (m_mix && m_pos < m_fast) ? 3 : 2;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Apply the upcoming clock edge to the reference, then compare after it.
  task automatic cyc(input string tag);
    string t;
    if (!out_en) begin
      m_st = 0; m_blank = 0; m_pos = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_blank = LB;
    end else if (m_st == 1) begin
      if (m_blank > 0) m_blank--;
      else if (trip) begin
        m_st = 2; m_pos = 0;
        m_len = ref_off(src_sel, toff_load);
        m_fast = ref_split(m_len, fast_load);
        m_mix = ref_mixed(src_sel, full_step, cur_rising);
      end
    end else begin
      if (m_pos + 1 >= m_len) begin m_st = 1; m_blank = LB; end
      else m_pos++;
    end
    @(negedge clk);
    #0.5;
    t = tag;
    if (t == "") t = !out_en ? "R9" : (m_st == 2 ? (m_mix ? "R5" : "R4") : "R3");
    chk(t, phase, ref_phase());
  endtask

  // Drive one trip after blanking, then time the whole off interval.
  task automatic trip_run(input int s, input bit fs, input bit up, input int tl,
                          input int fl, input string tag);
    int n_off, n_fast, exp_len, exp_fast;
    out_en = 1; src_sel = 2'(s); full_step = fs; cur_rising = up;
    toff_load = LW'(tl); fast_load = LW'(fl);
    trip = 1;
    while (!(m_st == 1 && m_blank == 0)) cyc("R2");
    cyc(tag);
    trip = 0;
    exp_len = ref_off(s, tl);
    exp_fast = ref_mixed(s, fs, up) ? ref_split(exp_len, fl) : 0;
    n_off = 0; n_fast = 0;
    while (phase[1] && n_off < 300) begin
      n_off++;
      if (phase == 2'b11) n_fast++;
      cyc(tag);
    end
    chk({tag, " off length"}, n_off, exp_len);
    chk({tag, " fast length"}, n_fast, exp_fast);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    out_en = 1;
    repeat (3) @(negedge clk);
    #0.5 chk("R1 in reset", phase, 0);
    rst_n = 1;
    chk("R1 after reset", phase, 0);

    trip_run(0, 0, 1, 0, 0, "R6 auto rising");
    trip_run(0, 0, 0, 0, 0, "R6 auto falling");
    trip_run(0, 1, 0, 0, 0, "R6 auto full step");
    trip_run(1, 0, 1, 0, 0, "R7 both rising");
    trip_run(1, 0, 0, 0, 0, "R7 both falling");
    trip_run(1, 1, 1, 0, 0, "R7 both full step");
    trip_run(2, 1, 0, 9, 0, "R8 prog full step");
    trip_run(3, 0, 1, 7, 5, "R8 prog split");
    trip_run(2, 0, 0, 4, 10, "R5 split clamp");
    trip_run(2, 0, 0, 2, 0, "R5 split zero");
    trip_run(2, 0, 0, 0, 0, "R4 zero load");

    // R4: a load change during the off-time does not alter it.
    trip = 1; src_sel = 2'd2; toff_load = 8'd10;
    while (!(m_st == 1 && m_blank == 0)) cyc("R2");
    cyc("R4"); trip = 0; toff_load = 8'd3;
    repeat (12) cyc("R4 latched");

    // R9: disable in the middle of an off-time, then resume.
    trip = 1;
    while (!(m_st == 1 && m_blank == 0)) cyc("R2");
    cyc("R3"); trip = 0;
    repeat (3) cyc("R3");
    out_en = 0; #0.5 chk("R9 same cycle", phase, 0);
    cyc("R9"); cyc("R9");
    out_en = 1; trip = 1;
    repeat (LB + 3) cyc("R9 resume");
    trip = 0;

    // Random traffic.
    for (int i = 0; i < 4000; i++) begin
      out_en     = ($urandom % 60) != 0;
      trip       = ($urandom % 3) == 0;
      src_sel    = 2'($urandom % 4);
      full_step  = ($urandom % 4) == 0;
      cur_rising = $urandom % 2;
      toff_load  = LW'(($urandom % 8 == 0) ? 0 : 3 + $urandom % 18);
      fast_load  = LW'(($urandom % 2) ? 0 : $urandom % 12);
      cyc("");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule